// File: doc/BRIEF.md
# Page Permission and Fault Code Checker

This block sits at the end of a page-table walk. The walker hands it the permissions gathered along the walk: the user, writable and no-execute attributes, plus the 4-bit protection key of the leaf entry. It also receives the requesting access (load, store or fetch, at user or supervisor privilege), the paging control bits and two key-rights registers. One clock cycle later it reports whether the access may proceed and which of read, write and execute the translation grants.

When the access is refused, or when the walker already flagged a not-present or reserved-bit condition, the block produces the page-fault error code bit for bit. It also outputs the faulting virtual address so that a fault-address register can capture it. In long mode it first checks that the virtual address is canonical. A non-canonical address raises a general-protection fault, which takes the place of any page fault.

Top module: `page_perm_check`

## Requirements
- R1: With `i_long_mode`=1, the address is shifted arithmetically right by 47 (by 56 when `i_la57`=1). If the result is neither 0 nor all ones, the response has `o_gp`=1, `o_pf`=0, `o_allow`=0, `o_prot`=0, `o_err`=0 and `o_fault_va`=address. This outranks every other fault. With `i_long_mode`=0 the check is skipped.
- R2: `i_walk_notp` gives a page fault with error base 0. Otherwise `i_walk_rsvd` gives a page fault with base bit 3. A not-present walk outranks the reserved-bit flag and all permission checks.
- R3: A user access (`i_user`=1) to a page whose user bit is 0 is a protection fault (base bit 0). It is reported as such even when the key rights would also deny the access.
- R4: Read (`o_prot` bit 0) is granted unless `i_smap`=1 and the page is a user page.
- R5: Write (`o_prot` bit 1) is granted only when read is granted, and then only if the page is writable, or if the access is supervisor and `i_wp`=0.
- R6: Execute (`o_prot` bit 2) is granted only if the no-execute attribute is 0. It is refused for a supervisor access to a user page while `i_smep`=1.
- R7: The rights come from `i_ukey_rights` (if `i_ukey_en`) for user pages and from `i_skey_rights` (if `i_skey_en`) for supervisor pages. If the matching enable is off, the rights are zero.
- R8: For key k, rights bit 2k (access-disable) removes read and write. Bit 2k+1 (write-disable) removes write, but only for user accesses or when `i_wp`=1. Execute is never removed by keys.
- R9: If the key-reduced rights lack the requested access, the result is a key fault with error bits 5 and 0 set. A fetch never produces a key fault.
- R10: Access code 1 is a store and 2 is a fetch; codes 0 and 3 are loads. The access is allowed when the final mask (base AND key) holds the requested bit. Otherwise it is a protection fault with base bit 0.
- R11: On every page fault, bit 2 is added for user accesses and bit 1 for stores. Bit 4 is added for fetches only when `i_nxe` or `i_smep` is 1.
- R12: Outputs are registered. The response to a request appears one clock later and `o_valid` follows `i_valid`. Without a request, and after reset, all outputs are 0.
- R13: On any fault, `o_allow`=0, `o_prot`=0 and `o_fault_va` is the request address. On success, `o_err`=0, `o_fault_va`=0 and `o_prot` carries the final mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Request present |
| i_va | input | 64 | Virtual address of the access |
| i_long_mode | input | 1 | Enables the canonical check |
| i_la57 | input | 1 | Five-level mode: canonical shift 56 instead of 47 |
| i_walk_notp | input | 1 | Walker found a non-present entry |
| i_walk_rsvd | input | 1 | Walker found a reserved bit set |
| i_pte_user | input | 1 | Accumulated user attribute |
| i_pte_write | input | 1 | Accumulated writable attribute |
| i_pte_nx | input | 1 | Accumulated no-execute attribute |
| i_pkey | input | 4 | Leaf protection key |
| i_user | input | 1 | Access is at user privilege |
| i_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| i_wp | input | 1 | Supervisor write-protect enable |
| i_smep | input | 1 | Supervisor fetch from user pages blocked |
| i_smap | input | 1 | Supervisor data access to user pages blocked |
| i_nxe | input | 1 | No-execute enabled (affects fetch bit in error code) |
| i_ukey_en | input | 1 | User-page key rights enabled |
| i_skey_en | input | 1 | Supervisor-page key rights enabled |
| i_ukey_rights | input | 32 | Key rights for user pages |
| i_skey_rights | input | 32 | Key rights for supervisor pages |
| o_valid | output | 1 | Response present |
| o_allow | output | 1 | Access permitted |
| o_prot | output | 3 | Granted mask: bit0 read, bit1 write, bit2 execute |
| o_pf | output | 1 | Page fault |
| o_gp | output | 1 | General-protection fault (non-canonical) |
| o_err | output | 16 | Page-fault error code |
| o_fault_va | output | 64 | Faulting virtual address |

## Verification
The same request can be refused both by its key rights and by its base permissions. Which cause is reported decides whether error bit 5 appears. The bench provokes this in directed cases and in random traffic:
- a user store to a supervisor page whose key is access-disabled must report a plain protection fault;
- a user store to a read-only user page with write-disable set must report the key fault;
- a non-canonical address paired with a walker fault must report only the general-protection fault.

Each response is judged against a reference model in the bench that applies the check order stated in the requirements.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSV   = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_NOTP = 3'd1,
    FLT_RSVD = 3'd2,
    FLT_PROT = 3'd3,
    FLT_PKEY = 3'd4
  } flt_e;

  // permission mask bit positions
  localparam int P_R = 0;
  localparam int P_W = 1;
  localparam int P_X = 2;

  // error code bit positions
  localparam int EC_P    = 0;
  localparam int EC_W    = 1;
  localparam int EC_U    = 2;
  localparam int EC_RSVD = 3;
  localparam int EC_ID   = 4;
  localparam int EC_PK   = 5;
endpackage

// File: rtl/pgchk_canon.sv
module pgchk_canon #(
  parameter int VA_W     = 64,
  parameter int SHIFT_4L = 47,
  parameter int SHIFT_5L = 56
) (
  input  logic [VA_W-1:0] va,
  input  logic            long_mode,
  input  logic            la57,
  output logic            noncanon
);
  localparam logic [VA_W-1:0] ONE   = 1;
  localparam logic [VA_W-1:0] HI_4L = ~((ONE << SHIFT_4L) - ONE);
  localparam logic [VA_W-1:0] HI_5L = ~((ONE << SHIFT_5L) - ONE);

  logic [VA_W-1:0] hi_mask;
  logic [VA_W-1:0] hi_bits;

  always_comb begin
    hi_mask  = la57 ? HI_5L : HI_4L;
    hi_bits  = va & hi_mask;
    noncanon = long_mode && (hi_bits != '0) && (hi_bits != hi_mask);
  end
endmodule

// File: rtl/pgchk_rights.sv
module pgchk_rights
  import pgchk_pkg::*;
#(
  parameter int NKEY = 16,
  localparam int KEY_W = $clog2(NKEY),
  localparam int RW    = 2 * NKEY
) (
  input  logic             pte_user,
  input  logic             pte_write,
  input  logic             pte_nx,
  input  logic [KEY_W-1:0] pkey,
  input  logic             usr,
  input  logic             wp,
  input  logic             smep,
  input  logic             smap,
  input  logic             ukey_en,
  input  logic             skey_en,
  input  logic [RW-1:0]    urights,
  input  logic [RW-1:0]    srights,
  output logic [2:0]       base_prot,
  output logic [2:0]       key_prot
);
  logic [RW-1:0]  sel;
  logic [KEY_W:0] idx_ad;
  logic [KEY_W:0] idx_wd;
  logic           ad;
  logic           wd;

  assign idx_ad = {pkey, 1'b0};
  assign idx_wd = {pkey, 1'b1};

  always_comb begin
    // base permissions from the walk and supervisor protections
    base_prot[P_R] = !(smap && pte_user);
    base_prot[P_W] = base_prot[P_R] && (pte_write || !(usr || wp));
    base_prot[P_X] = !pte_nx && (usr || !(smep && pte_user));

    // key rights, register picked by the page's user attribute
    if (pte_user) sel = ukey_en ? urights : '0;
    else          sel = skey_en ? srights : '0;
    ad = sel[idx_ad];
    wd = sel[idx_wd];

    key_prot[P_R] = !ad;
    key_prot[P_W] = !ad && !(wd && (usr || wp));
    key_prot[P_X] = 1'b1;
  end
endmodule

// File: rtl/pgchk_errcode.sv
module pgchk_errcode
  import pgchk_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  flt_e             flt,
  input  logic             usr,
  input  logic             store,
  input  logic             fetch,
  input  logic             nxe,
  input  logic             smep,
  output logic [ERR_W-1:0] code
);
  always_comb begin
    code = '0;
    unique case (flt)
      FLT_RSVD: code[EC_RSVD] = 1'b1;
      FLT_PROT: code[EC_P]    = 1'b1;
      FLT_PKEY: begin
        code[EC_P]  = 1'b1;
        code[EC_PK] = 1'b1;
      end
      default: ;
    endcase
    if (flt != FLT_NONE) begin
      code[EC_U]  = usr;
      code[EC_W]  = store;
      code[EC_ID] = fetch && (nxe || smep);
    end
  end
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
  import pgchk_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int NKEY     = 16,
  parameter int ERR_W    = 16,
  parameter int SHIFT_4L = 47,
  parameter int SHIFT_5L = 56
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      i_valid,
  input  logic [VA_W-1:0]           i_va,
  input  logic                      i_long_mode,
  input  logic                      i_la57,
  input  logic                      i_walk_notp,
  input  logic                      i_walk_rsvd,
  input  logic                      i_pte_user,
  input  logic                      i_pte_write,
  input  logic                      i_pte_nx,
  input  logic [$clog2(NKEY)-1:0]   i_pkey,
  input  logic                      i_user,
  input  logic [1:0]                i_acc,
  input  logic                      i_wp,
  input  logic                      i_smep,
  input  logic                      i_smap,
  input  logic                      i_nxe,
  input  logic                      i_ukey_en,
  input  logic                      i_skey_en,
  input  logic [2*NKEY-1:0]         i_ukey_rights,
  input  logic [2*NKEY-1:0]         i_skey_rights,
  output logic                      o_valid,
  output logic                      o_allow,
  output logic [2:0]                o_prot,
  output logic                      o_pf,
  output logic                      o_gp,
  output logic [ERR_W-1:0]          o_err,
  output logic [VA_W-1:0]           o_fault_va
);
  logic             noncanon;
  logic [2:0]       base_prot;
  logic [2:0]       key_prot;
  logic [2:0]       fin_prot;
  logic             acc_store;
  logic             acc_fetch;
  logic             key_ok;
  logic             fin_ok;
  flt_e             flt;
  logic [ERR_W-1:0] code;

  pgchk_canon #(
    .VA_W(VA_W), .SHIFT_4L(SHIFT_4L), .SHIFT_5L(SHIFT_5L)
  ) u_canon (
    .va(i_va), .long_mode(i_long_mode), .la57(i_la57), .noncanon(noncanon)
  );

  pgchk_rights #(.NKEY(NKEY)) u_rights (
    .pte_user(i_pte_user), .pte_write(i_pte_write), .pte_nx(i_pte_nx),
    .pkey(i_pkey), .usr(i_user), .wp(i_wp), .smep(i_smep), .smap(i_smap),
    .ukey_en(i_ukey_en), .skey_en(i_skey_en),
    .urights(i_ukey_rights), .srights(i_skey_rights),
    .base_prot(base_prot), .key_prot(key_prot)
  );

  always_comb begin
    acc_store = (i_acc == ACC_STORE);
    acc_fetch = (i_acc == ACC_FETCH);
    fin_prot  = base_prot & key_prot;
    key_ok    = acc_store ? key_prot[P_W] : acc_fetch ? key_prot[P_X] : key_prot[P_R];
    fin_ok    = acc_store ? fin_prot[P_W] : acc_fetch ? fin_prot[P_X] : fin_prot[P_R];

    if (i_walk_notp)                  flt = FLT_NOTP;
    else if (i_walk_rsvd)             flt = FLT_RSVD;
    else if (i_user && !i_pte_user)   flt = FLT_PROT;
    else if (!key_ok)                 flt = FLT_PKEY;
    else if (!fin_ok)                 flt = FLT_PROT;
    else                              flt = FLT_NONE;
  end

  pgchk_errcode #(.ERR_W(ERR_W)) u_err (
    .flt(flt), .usr(i_user), .store(acc_store), .fetch(acc_fetch),
    .nxe(i_nxe), .smep(i_smep), .code(code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid    <= 1'b0;
      o_allow    <= 1'b0;
      o_prot     <= '0;
      o_pf       <= 1'b0;
      o_gp       <= 1'b0;
      o_err      <= '0;
      o_fault_va <= '0;
    end else begin
      o_valid <= i_valid;
      if (i_valid) begin
        o_gp       <= noncanon;
        o_pf       <= !noncanon && (flt != FLT_NONE);
        o_allow    <= !noncanon && (flt == FLT_NONE);
        o_prot     <= (!noncanon && flt == FLT_NONE) ? fin_prot : 3'b000;
        o_err      <= noncanon ? '0 : code;
        o_fault_va <= (noncanon || flt != FLT_NONE) ? i_va : '0;
      end else begin
        o_gp       <= 1'b0;
        o_pf       <= 1'b0;
        o_allow    <= 1'b0;
        o_prot     <= '0;
        o_err      <= '0;
        o_fault_va <= '0;
      end
    end
  end

  // R12
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    i_valid |=> o_valid);

  // R13
  allow_clean_chk: assert property (@(posedge clk) disable iff (rst)
    o_allow |-> (!o_pf && !o_gp && o_fault_va == '0 && o_err == '0));

  // R1
  gp_clean_chk: assert property (@(posedge clk) disable iff (rst)
    o_gp |-> (!o_pf && !o_allow && o_err == '0));

  // R9
  pk_code_chk: assert property (@(posedge clk) disable iff (rst)
    o_err[EC_PK] |-> (o_err[EC_P] && !o_err[EC_ID] && o_pf));

  // R5
  write_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    o_prot[P_W] |-> o_prot[P_R]);

  // R10
  allow_has_prot_chk: assert property (@(posedge clk) disable iff (rst)
    o_allow |-> (o_prot != 3'b000));
endmodule

// File: tb/page_perm_check_tb.sv
`timescale 1ns/1ps
module page_perm_check_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        i_valid = 1'b0;
  logic [63:0] i_va = '0;
  logic        i_long_mode = 1'b0, i_la57 = 1'b0;
  logic        i_walk_notp = 1'b0, i_walk_rsvd = 1'b0;
  logic        i_pte_user = 1'b0, i_pte_write = 1'b0, i_pte_nx = 1'b0;
  logic [3:0]  i_pkey = '0;
  logic        i_user = 1'b0;
  logic [1:0]  i_acc = '0;
  logic        i_wp = 1'b0, i_smep = 1'b0, i_smap = 1'b0, i_nxe = 1'b0;
  logic        i_ukey_en = 1'b0, i_skey_en = 1'b0;
  logic [31:0] i_ukey_rights = '0, i_skey_rights = '0;
  logic        o_valid, o_allow, o_pf, o_gp;
  logic [2:0]  o_prot;
  logic [15:0] o_err;
  logic [63:0] o_fault_va;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  page_perm_check u_dut (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_va(i_va),
    .i_long_mode(i_long_mode), .i_la57(i_la57),
    .i_walk_notp(i_walk_notp), .i_walk_rsvd(i_walk_rsvd),
    .i_pte_user(i_pte_user), .i_pte_write(i_pte_write), .i_pte_nx(i_pte_nx),
    .i_pkey(i_pkey), .i_user(i_user), .i_acc(i_acc), .i_wp(i_wp),
    .i_smep(i_smep), .i_smap(i_smap), .i_nxe(i_nxe),
    .i_ukey_en(i_ukey_en), .i_skey_en(i_skey_en),
    .i_ukey_rights(i_ukey_rights), .i_skey_rights(i_skey_rights),
    .o_valid(o_valid), .o_allow(o_allow), .o_prot(o_prot), .o_pf(o_pf),
    .o_gp(o_gp), .o_err(o_err), .o_fault_va(o_fault_va)
  );

  // packed result: valid, allow, prot, pf, gp, err, fault_va
  typedef struct packed {
    logic        v;
    logic        allow;
    logic [2:0]  prot;
    logic        pf;
    logic        gp;
    logic [15:0] err;
    logic [63:0] fva;
  } res_t;

  string   mtag;

  function automatic res_t model();
    res_t r;
    logic signed [63:0] sx;
    logic nc, st, fe, rr, ww, xx, kr, kw, ad, wd, acc_ok, key_acc_ok;
    logic [31:0] rights;
    logic [2:0] fin;
    int kind; // 0 ok,1 notp,2 rsvd,3 prot,4 pkey
    r = '0;
    r.v = 1'b1;
    sx = $signed(i_va) >>> (i_la57 ? 56 : 47);
    nc = i_long_mode && !(sx == 0 || sx == -1);
    st = (i_acc == 2'd1);
    fe = (i_acc == 2'd2);
    rr = !(i_smap && i_pte_user);
    ww = rr && (i_pte_write || (!i_user && !i_wp));
    xx = !i_pte_nx && (i_user || !(i_smep && i_pte_user));
    rights = i_pte_user ? (i_ukey_en ? i_ukey_rights : 32'h0)
                        : (i_skey_en ? i_skey_rights : 32'h0);
    ad = rights[2*i_pkey];
    wd = rights[2*i_pkey+1];
    kr = !ad;
    kw = !ad && !(wd && (i_user || i_wp));
    fin = {xx, ww && kw, rr && kr};
    key_acc_ok = st ? kw : (fe ? 1'b1 : kr);
    acc_ok = st ? fin[1] : (fe ? fin[2] : fin[0]);
    if (i_walk_notp)                 begin kind = 1; mtag = "R2"; end
    else if (i_walk_rsvd)            begin kind = 2; mtag = "R2"; end
    else if (i_user && !i_pte_user)  begin kind = 3; mtag = "R3"; end
    else if (!key_acc_ok)            begin kind = 4; mtag = "R9"; end
    else if (!acc_ok)                begin kind = 3; mtag = "R10"; end
    else                             begin kind = 0; mtag = "R13"; end
    if (nc) begin
      mtag = "R1";
      r.gp = 1'b1;
      r.fva = i_va;
    end else if (kind == 0) begin
      r.allow = 1'b1;
      r.prot = fin;
    end else begin
      r.pf = 1'b1;
      r.fva = i_va;
      case (kind)
        2: r.err = 16'h0008;
        3: r.err = 16'h0001;
        4: r.err = 16'h0021;
        default: r.err = 16'h0000;
      endcase
      if (i_user) r.err = r.err | 16'h0004;
      if (st) r.err = r.err | 16'h0002;
      if (fe && (i_nxe || i_smep)) r.err = r.err | 16'h0010;
    end
    return r;
  endfunction

  function automatic res_t got();
    return '{o_valid, o_allow, o_prot, o_pf, o_gp, o_err, o_fault_va};
  endfunction

  task automatic compare(input res_t exp, input string tag);
    res_t act;
    act = got();
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act v=%0b allow=%0b prot=%03b pf=%0b gp=%0b err=%h va=%h | exp v=%0b allow=%0b prot=%03b pf=%0b gp=%0b err=%h va=%h",
        tag, act.v, act.allow, act.prot, act.pf, act.gp, act.err, act.fva,
        exp.v, exp.allow, exp.prot, exp.pf, exp.gp, exp.err, exp.fva);
    end
  endtask

  // inputs already set at a falling edge; result is sampled one cycle later
  task automatic run(input string tag);
    res_t exp;
    string t;
    i_valid = 1'b1;
    exp = model();
    t = {tag, "/", mtag};
    @(posedge clk);
    @(negedge clk);
    compare(exp, t);
  endtask

  task automatic clear_req();
    i_valid = 1'b0; i_va = '0; i_long_mode = 0; i_la57 = 0;
    i_walk_notp = 0; i_walk_rsvd = 0; i_pte_user = 0; i_pte_write = 0;
    i_pte_nx = 0; i_pkey = '0; i_user = 0; i_acc = 2'd0; i_wp = 0;
    i_smep = 0; i_smap = 0; i_nxe = 0; i_ukey_en = 0; i_skey_en = 0;
    i_ukey_rights = '0; i_skey_rights = '0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: act=timeout exp=completion");
    report();
  end

  initial begin
    int unsigned seed;
    res_t z;
    seed = 32'd1234;
    void'($urandom(seed));
    z = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: outputs zero in reset
    compare(z, "R12 reset");
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    compare(z, "R12 idle");

    // R1: bit 47 set is non-canonical in four-level mode, wins over walker fault
    clear_req(); i_long_mode = 1; i_va = 64'h0000_8000_0000_1000; i_walk_notp = 1;
    run("R1 noncanon+walk");
    // R1: same address is canonical with five-level shift
    clear_req(); i_long_mode = 1; i_la57 = 1; i_va = 64'h0000_8000_0000_1000;
    run("R1 la57 canonical");
    // R1: upper sign extension accepted
    clear_req(); i_long_mode = 1; i_va = 64'hFFFF_8000_0000_0000;
    run("R1 negative canonical");
    // R2: not-present outranks reserved
    clear_req(); i_walk_notp = 1; i_walk_rsvd = 1; i_acc = 2'd1; i_va = 64'h1234;
    run("R2 notp over rsvd");
    clear_req(); i_walk_rsvd = 1; i_user = 1; i_pte_user = 1; i_va = 64'h5000;
    run("R2 rsvd");
    // R3: user store to supervisor page with access-disabled key
    clear_req(); i_user = 1; i_acc = 2'd1; i_skey_en = 1; i_skey_rights = 32'hFFFF_FFFF;
    i_pte_write = 1; i_va = 64'h7000;
    run("R3 user on sup page");
    // R4: smap blocks supervisor load of user page
    clear_req(); i_smap = 1; i_pte_user = 1; i_pte_write = 1; i_va = 64'h8000;
    run("R4 smap load");
    // R5: supervisor store to read-only page with wp off is allowed
    clear_req(); i_acc = 2'd1; i_va = 64'h9000;
    run("R5 sup store wp0");
    clear_req(); i_acc = 2'd1; i_wp = 1; i_va = 64'h9000;
    run("R5 sup store wp1");
    // R6: supervisor fetch of user page with smep
    clear_req(); i_acc = 2'd2; i_smep = 1; i_pte_user = 1; i_va = 64'hA000;
    run("R6 smep fetch");
    clear_req(); i_acc = 2'd2; i_pte_nx = 1; i_nxe = 1; i_va = 64'hA040;
    run("R6 nx fetch");
    // R7: supervisor page ignores user rights register
    clear_req(); i_ukey_en = 1; i_ukey_rights = 32'hFFFF_FFFF; i_pkey = 4'd3;
    i_pte_write = 1; i_acc = 2'd1; i_va = 64'hB000;
    run("R7 sup page user rights");
    // R8: write-disable on user store (also key beats read-only base denial)
    clear_req(); i_user = 1; i_pte_user = 1; i_acc = 2'd1; i_ukey_en = 1;
    i_pkey = 4'd15; i_ukey_rights = 32'h8000_0000; i_va = 64'hC000;
    run("R8 wd user store");
    // R8: write-disable ignored for supervisor with wp off
    clear_req(); i_acc = 2'd1; i_skey_en = 1; i_pkey = 4'd2;
    i_skey_rights = 32'h0000_0020; i_pte_write = 1; i_va = 64'hC100;
    run("R8 wd sup wp0");
    // R9: fetch through access-disabled key is not a key fault
    clear_req(); i_acc = 2'd2; i_ukey_en = 1; i_user = 1; i_pte_user = 1;
    i_ukey_rights = 32'h0000_0001; i_va = 64'hD000;
    run("R9 fetch key ad");
    // R10: access code 3 behaves as load
    clear_req(); i_acc = 2'd3; i_smap = 1; i_pte_user = 1; i_va = 64'hD100;
    run("R10 code3 load");
    // R11: fetch fault without nxe/smep has no fetch bit
    clear_req(); i_acc = 2'd2; i_walk_notp = 1; i_va = 64'hE000;
    run("R11 fetch no id");
    clear_req(); i_acc = 2'd2; i_walk_notp = 1; i_nxe = 1; i_user = 1; i_va = 64'hE000;
    run("R11 fetch id");

    // R12: no request gives zero outputs
    clear_req(); i_va = 64'hFFFF_0000_DEAD_0000; i_walk_notp = 1;
    @(posedge clk); @(negedge clk);
    compare(z, "R12 no request");

    for (int i = 0; i < 4000; i++) begin
      logic [63:0] v;
      clear_req();
      v = {$urandom(), $urandom()};
      if ($urandom_range(0, 7) != 0) v = {{17{v[46]}}, v[46:0]};
      i_va = v;
      i_long_mode = $urandom_range(0, 3) != 0;
      i_la57 = $urandom_range(0, 1);
      i_walk_notp = $urandom_range(0, 15) == 0;
      i_walk_rsvd = $urandom_range(0, 15) == 0;
      i_pte_user = $urandom_range(0, 1);
      i_pte_write = $urandom_range(0, 1);
      i_pte_nx = $urandom_range(0, 1);
      i_pkey = 4'($urandom_range(0, 15));
      i_user = $urandom_range(0, 1);
      i_acc = 2'($urandom_range(0, 3));
      i_wp = $urandom_range(0, 1);
      i_smep = $urandom_range(0, 1);
      i_smap = $urandom_range(0, 1);
      i_nxe = $urandom_range(0, 1);
      i_ukey_en = $urandom_range(0, 1);
      i_skey_en = $urandom_range(0, 1);
      i_ukey_rights = $urandom() & $urandom();
      i_skey_rights = $urandom() & $urandom();
      run("random R4 R5 R6 R7 R8 R11");
    end

    clear_req();
    @(posedge clk); @(negedge clk);
    compare(z, "R12 final idle");
    report();
  end
endmodule